// File: doc/BRIEF.md
# Sleep Mode and Clock-Gating Controller

This controller sits beside a small microcontroller core and decides which clock domains run. When software has set a sleep-enable bit and the core executes its sleep instruction (signalled by a one-cycle strobe), the controller latches a 3-bit mode code. It then drops the enables for the CPU, non-volatile memory, I/O and ADC clock domains, and for the main oscillator, in the pattern that the chosen mode calls for.

While asleep, the controller accepts only the wake sources that belong to that mode. When a wake is accepted it first lets the oscillator restart, but only if it had been stopped. It then holds the CPU halted for four cycles with its clocks running and finally hands control back through the interrupt path. A reset request during sleep takes a separate exit that points the core at its reset vector. Nothing here ever clears stored state.

Top module: `sleep_gate_ctrl`

## Requirements
- R1: A sleep strobe is acted on only when `sleep_en` is 1 in the same cycle. With `sleep_en` at 0 the core stays running and all clock enables stay high.
- R2: Mode codes are 000 Idle, 001 ADC Noise Reduction, 010 Power-down and 100 Standby. A strobe carrying any other code is ignored, and so is a strobe that arrives while the core is not running.
- R3: Enables while asleep: in Idle, I/O, ADC and oscillator are on. In ADC Noise Reduction, only ADC and oscillator are on. In Standby, only the oscillator is on. In Power-down, all are off. CPU and memory enables are off in every sleep mode, and all enables are on while running.
- R4: Wake sources: in Idle, `irq_any`. In ADC Noise Reduction, the qualified level input, `wk_pin`, `wk_adc`, `wk_wdt` and `wk_vmon`. In Standby and Power-down, the qualified level input, `wk_pin` and `wk_wdt`. Any other input leaves the core asleep.
- R5: `wk_lvl` wakes the core only if it is high on two consecutive sleeping cycles. A single-cycle high is ignored.
- R6: Entering Idle or ADC Noise Reduction with `adc_on` high gives a one-cycle `adc_start` in the first sleeping cycle. No other entry produces the pulse.
- R7: A wake from Power-down with `startup_cyc` = S > 0 holds the oscillator on, with domains gated, for S `slow_tick` pulses before the halt. With S = 0, and in every other mode, the halt starts right after the wake.
- R8: The halt lasts exactly four cycles with `cpu_halt` high and all clock enables high. The core then runs again and `wake_irq` pulses for one cycle.
- R9: `ext_rst` in any non-running cycle returns the core to running on the next cycle with a one-cycle `wake_rst` and no `wake_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on controller clock |
| rst_n | input | 1 | active-low controller reset |
| sleep_en | input | 1 | sleep-enable control bit |
| mode_sel | input | 3 | sleep mode code |
| sleep_stb | input | 1 | sleep instruction executed |
| adc_on | input | 1 | ADC is enabled |
| irq_any | input | 1 | any enabled interrupt pending |
| wk_lvl | input | 1 | external level wake input |
| wk_pin | input | 1 | pin-change wake |
| wk_adc | input | 1 | ADC conversion complete |
| wk_wdt | input | 1 | watchdog wake |
| wk_vmon | input | 1 | supply-voltage monitor wake |
| ext_rst | input | 1 | reset request during sleep |
| slow_tick | input | 1 | one-cycle tick of the slow always-on clock |
| startup_cyc | input | CW | oscillator start-up length in slow ticks |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_nvm_en | output | 1 | program memory clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_adc_en | output | 1 | ADC clock enable |
| osc_en | output | 1 | main oscillator enable |
| adc_start | output | 1 | start-conversion pulse |
| cpu_halt | output | 1 | CPU held halted |
| wake_irq | output | 1 | release into the interrupt path |
| wake_rst | output | 1 | release into the reset vector |

## Verification
A strobe or wake input applied before a clock edge shows up in the clock enables and `cpu_halt` right after that edge, and `adc_start` is also due in that first sleeping cycle. `wake_irq` comes four edges after the halt begins, and `wake_rst` follows `ext_rst` by one edge. For a Power-down wake with a start-up count, the halt waits for the S-th slow tick. A behavioural model in the bench advances on the same edges and is compared at every falling edge, so each output is checked in exactly the cycle it is due. Directed checks sample at fixed edge counts from the stimulus that match these latencies.

// File: rtl/sleep_gate_ctrl.sv
module sleep_gate_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_en,
  input  logic [2:0]    mode_sel,
  input  logic          sleep_stb,
  input  logic          adc_on,
  input  logic          irq_any,
  input  logic          wk_lvl,
  input  logic          wk_pin,
  input  logic          wk_adc,
  input  logic          wk_wdt,
  input  logic          wk_vmon,
  input  logic          ext_rst,
  input  logic          slow_tick,
  input  logic [CW-1:0] startup_cyc,
  output logic          clk_cpu_en,
  output logic          clk_nvm_en,
  output logic          clk_io_en,
  output logic          clk_adc_en,
  output logic          osc_en,
  output logic          adc_start,
  output logic          cpu_halt,
  output logic          wake_irq,
  output logic          wake_rst
);
  localparam int HALT_LEN = 4;
  localparam int HW = $clog2(HALT_LEN);

  typedef enum logic [1:0] {RUN, SLP, STUP, HLT} st_t;

  st_t           st;
  logic [2:0]    md;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hcnt;
  logic          lvl_q;

  wire m_idle = (md == 3'b000);
  wire m_adcn = (md == 3'b001);
  wire m_pdn  = (md == 3'b010);

  wire code_ok = (mode_sel == 3'b000) || (mode_sel == 3'b001) ||
                 (mode_sel == 3'b010) || (mode_sel == 3'b100);
  wire go      = (st == RUN) && sleep_stb && sleep_en && code_ok;

  wire lvl_ok  = wk_lvl && lvl_q;
  wire base_wk = lvl_ok || wk_pin || wk_wdt;
  wire wake    = m_idle ? irq_any :
                 m_adcn ? (base_wk || wk_adc || wk_vmon) : base_wk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RUN;
      md        <= 3'b000;
      cnt       <= '0;
      hcnt      <= '0;
      lvl_q     <= 1'b0;
      adc_start <= 1'b0;
      wake_irq  <= 1'b0;
      wake_rst  <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      wake_irq  <= 1'b0;
      wake_rst  <= 1'b0;
      lvl_q     <= (st == SLP) && wk_lvl;
      case (st)
        RUN: if (go) begin
          st        <= SLP;
          md        <= mode_sel;
          adc_start <= adc_on && (mode_sel[2:1] == 2'b00);
        end
        SLP: if (ext_rst) begin
          st       <= RUN;
          wake_rst <= 1'b1;
        end else if (wake) begin
          if (m_pdn && startup_cyc != '0) begin
            st  <= STUP;
            cnt <= startup_cyc;
          end else begin
            st   <= HLT;
            hcnt <= HW'(HALT_LEN - 1);
          end
        end
        STUP: if (ext_rst) begin
          st       <= RUN;
          wake_rst <= 1'b1;
        end else if (slow_tick) begin
          if (cnt == CW'(1)) begin
            st   <= HLT;
            hcnt <= HW'(HALT_LEN - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        HLT: if (ext_rst) begin
          st       <= RUN;
          wake_rst <= 1'b1;
        end else if (hcnt == '0) begin
          st       <= RUN;
          wake_irq <= 1'b1;
        end else begin
          hcnt <= hcnt - 1'b1;
        end
        default: st <= RUN;
      endcase
    end
  end

  wire awake = (st == RUN) || (st == HLT);
  wire asleep = (st == SLP);

  assign clk_cpu_en = awake;
  assign clk_nvm_en = awake;
  assign clk_io_en  = awake || (asleep && m_idle);
  assign clk_adc_en = awake || (asleep && (m_idle || m_adcn));
  assign osc_en     = awake || (st == STUP) || (asleep && !m_pdn);
  assign cpu_halt   = (st != RUN);
endmodule

module sleep_gate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_en,
  input logic [2:0] mode_sel,
  input logic       sleep_stb,
  input logic       clk_cpu_en,
  input logic       clk_nvm_en,
  input logic       clk_io_en,
  input logic       clk_adc_en,
  input logic       osc_en,
  input logic       adc_start,
  input logic       cpu_halt,
  input logic       wake_irq,
  input logic       wake_rst
);
  // R1
  strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && sleep_stb && !sleep_en) |=> !cpu_halt);

  // R2
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && sleep_stb && !(mode_sel inside {3'b000, 3'b001, 3'b010, 3'b100})) |=> !cpu_halt);

  // R3
  osc_off_gates_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!clk_cpu_en && !clk_nvm_en && !clk_io_en && !clk_adc_en));

  // R3
  running_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_halt |-> (clk_cpu_en && clk_nvm_en && clk_io_en && clk_adc_en && osc_en));

  // R6
  adc_pulse_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (clk_adc_en && !clk_cpu_en && cpu_halt));

  // R6
  adc_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R8
  halt_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (!cpu_halt && $past(cpu_halt) && $past(clk_cpu_en) && $past(cpu_halt, 4) && $past(clk_cpu_en, 4)));

  // R9
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |-> (!cpu_halt && !wake_irq && $past(cpu_halt)));
endmodule

bind sleep_gate_ctrl sleep_gate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
  .sleep_stb(sleep_stb), .clk_cpu_en(clk_cpu_en), .clk_nvm_en(clk_nvm_en),
  .clk_io_en(clk_io_en), .clk_adc_en(clk_adc_en), .osc_en(osc_en),
  .adc_start(adc_start), .cpu_halt(cpu_halt), .wake_irq(wake_irq),
  .wake_rst(wake_rst)
);

// File: tb/sleep_gate_ctrl_tb.sv
module sleep_gate_ctrl_tb;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_en = 0, sleep_stb = 0, adc_on = 0, irq_any = 0;
  logic wk_lvl = 0, wk_pin = 0, wk_adc = 0, wk_wdt = 0, wk_vmon = 0;
  logic ext_rst = 0, slow_tick = 0;
  logic [2:0] mode_sel = 3'b000;
  logic [CW-1:0] startup_cyc = '0;
  logic clk_cpu_en, clk_nvm_en, clk_io_en, clk_adc_en, osc_en;
  logic adc_start, cpu_halt, wake_irq, wake_rst;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sleep_gate_ctrl #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
    .sleep_stb(sleep_stb), .adc_on(adc_on), .irq_any(irq_any),
    .wk_lvl(wk_lvl), .wk_pin(wk_pin), .wk_adc(wk_adc), .wk_wdt(wk_wdt),
    .wk_vmon(wk_vmon), .ext_rst(ext_rst), .slow_tick(slow_tick),
    .startup_cyc(startup_cyc), .clk_cpu_en(clk_cpu_en),
    .clk_nvm_en(clk_nvm_en), .clk_io_en(clk_io_en), .clk_adc_en(clk_adc_en),
    .osc_en(osc_en), .adc_start(adc_start), .cpu_halt(cpu_halt),
    .wake_irq(wake_irq), .wake_rst(wake_rst)
  );

  // slow clock tick every third cycle
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    slow_tick <= (tdiv == 0);
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: phase 0 running, 1 asleep, 2 oscillator start, 3 halted
  int ph = 0, mm = 0, left = 0;
  bit prev_lvl = 0, e_ast = 0, e_wi = 0, e_wr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mm = 0; left = 0; prev_lvl = 0; e_ast = 0; e_wi = 0; e_wr = 0;
    end else begin
      bit woke, lvl_now;
      lvl_now = (ph == 1) && wk_lvl;
      e_ast = 0; e_wi = 0; e_wr = 0;
      case (mm)
        0: woke = irq_any;
        1: woke = (wk_lvl && prev_lvl) || wk_pin || wk_adc || wk_wdt || wk_vmon;
        default: woke = (wk_lvl && prev_lvl) || wk_pin || wk_wdt;
      endcase
      if (ph != 0 && ext_rst) begin
        ph = 0; e_wr = 1;
      end else if (ph == 0) begin
        if (sleep_stb && sleep_en && (mode_sel == 0 || mode_sel == 1 || mode_sel == 2 || mode_sel == 4)) begin
          ph = 1; mm = int'(mode_sel); e_ast = adc_on && mode_sel < 2;
        end
      end else if (ph == 1) begin
        if (woke) begin
          if (mm == 2 && startup_cyc != 0) begin ph = 2; left = int'(startup_cyc); end
          else begin ph = 3; left = 4; end
        end
      end else if (ph == 2) begin
        if (slow_tick) begin
          left--;
          if (left == 0) begin ph = 3; left = 4; end
        end
      end else begin
        left--;
        if (left == 0) begin ph = 0; e_wi = 1; end
      end
      prev_lvl = lvl_now;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit up;
      up = (ph == 0) || (ph == 3);
      chk("R3 cpu_en", clk_cpu_en, up);
      chk("R3 nvm_en", clk_nvm_en, up);
      chk("R3 io_en", clk_io_en, up || (ph == 1 && mm == 0));
      chk("R3 adc_en", clk_adc_en, up || (ph == 1 && mm < 2));
      chk("R7 osc_en", osc_en, up || ph == 2 || (ph == 1 && mm != 2));
      chk("R6 adc_start", adc_start, e_ast);
      chk("R8 cpu_halt", cpu_halt, ph != 0);
      chk("R8 wake_irq", wake_irq, e_wi);
      chk("R9 wake_rst", wake_rst, e_wr);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(input logic [2:0] m);
    sleep_en = 1; mode_sel = m; sleep_stb = 1;
    tick(1);
    sleep_stb = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    chk("R3 reset cpu_en", clk_cpu_en, 1);
    chk("R8 reset cpu_halt", cpu_halt, 0);

    sleep_en = 0; mode_sel = 3'b000; sleep_stb = 1;
    tick(1); sleep_stb = 0;
    chk("R1 disabled strobe", cpu_halt, 0);
    tick(1);

    enter(3'b011);
    chk("R2 reserved code", cpu_halt, 0);
    tick(1);

    adc_on = 1;
    enter(3'b000);
    chk("R6 idle adc pulse", adc_start, 1);
    chk("R3 idle io_en", clk_io_en, 1);
    chk("R3 idle cpu_en", clk_cpu_en, 0);
    tick(1);
    chk("R6 pulse ends", adc_start, 0);
    sleep_en = 1; mode_sel = 3'b010; sleep_stb = 1;
    tick(1); sleep_stb = 0;
    chk("R2 strobe while asleep", clk_io_en, 1);
    irq_any = 1; tick(1); irq_any = 0;
    chk("R8 halt clocks on", clk_cpu_en, 1);
    tick(3);
    chk("R8 halted fourth cycle", cpu_halt, 1);
    tick(1);
    chk("R8 released", cpu_halt, 0);
    chk("R8 wake_irq", wake_irq, 1);
    tick(1);
    chk("R8 wake_irq one cycle", wake_irq, 0);

    adc_on = 0;
    enter(3'b001);
    chk("R6 no pulse adc off", adc_start, 0);
    chk("R3 adcn io_en", clk_io_en, 0);
    chk("R3 adcn adc_en", clk_adc_en, 1);
    irq_any = 1; tick(2); irq_any = 0;
    chk("R4 irq ignored adcn", cpu_halt && !clk_cpu_en, 1);
    wk_vmon = 1; tick(1); wk_vmon = 0;
    chk("R4 vmon wakes adcn", clk_cpu_en, 1);
    tick(5);

    adc_on = 1;
    enter(3'b100);
    chk("R6 no pulse standby", adc_start, 0);
    chk("R3 standby osc", osc_en, 1);
    chk("R3 standby adc_en", clk_adc_en, 0);
    wk_adc = 1; tick(2); wk_adc = 0;
    chk("R4 adc ignored standby", clk_cpu_en, 0);
    wk_pin = 1; tick(1); wk_pin = 0;
    chk("R4 pin wakes standby", clk_cpu_en, 1);
    tick(5);

    startup_cyc = 8'd5;
    enter(3'b010);
    chk("R3 powerdown osc", osc_en, 0);
    wk_lvl = 1; tick(1); wk_lvl = 0; tick(2);
    chk("R5 glitch ignored", clk_cpu_en || osc_en, 0);
    wk_lvl = 1; tick(1);
    chk("R5 one sample not enough", osc_en, 0);
    tick(1); wk_lvl = 0;
    chk("R7 oscillator starting", osc_en, 1);
    chk("R7 domains still gated", clk_cpu_en, 0);
    tick(10);
    chk("R7 start-up not over", clk_cpu_en, 0);
    for (int i = 0; i < 40 && !clk_cpu_en; i++) tick(1);
    chk("R7 start-up ends in halt", cpu_halt && clk_cpu_en, 1);
    tick(5);

    startup_cyc = 8'd0;
    enter(3'b010);
    wk_wdt = 1; tick(1); wk_wdt = 0;
    chk("R7 zero start-up halts at once", cpu_halt && clk_cpu_en, 1);
    tick(5);

    startup_cyc = 8'd3;
    enter(3'b010);
    wk_wdt = 1; tick(1); wk_wdt = 0;
    ext_rst = 1; tick(1); ext_rst = 0;
    chk("R9 reset exit", wake_rst, 1);
    chk("R9 no interrupt exit", wake_irq, 0);
    chk("R9 running", cpu_halt, 0);
    tick(6);
    chk("R9 no late wake_irq", wake_irq, 0);

    enter(3'b000);
    ext_rst = 1; tick(1); ext_rst = 0;
    chk("R9 reset from idle", wake_rst, 1);
    tick(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule